// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pull-ups

This block is an 8-bit general-purpose I/O port attached to a simple processor data-memory bus. Software reaches it through three addresses. The first is a data latch. The second is a direction register. The third is a read-only location that returns the sampled levels on the pins. For every pin the block drives three pad controls: an output enable, an output value and a pull-up enable.

The data latch serves two purposes. On a pin whose direction bit is 1, the latch bit is the level the pin drives push-pull. On a pin whose direction bit is 0, the latch bit turns the weak pull-up on or off. A read of the latch address returns the stored byte. A read of the pin address returns the live pin level after it has passed through a two-stage synchronizer.

The bus has no flow control. A write takes effect on the clock edge that samples the write strobe. Read data is combinational from the address and the read strobe.

Top module: `gpio_port`

## Requirements
- R1: After reset, the latch and the direction register both read 0x00, and `pad_oe`, `pad_out` and `pad_pu` are all 0.
- R2: A write to address 0x18 stores the byte in the data latch. A read of 0x18 returns that stored byte, whatever the pins carry.
- R3: A write to address 0x17 stores the byte in the direction register, where a 1 bit marks an output pin. A read of 0x17 returns the stored byte.
- R4: A read of address 0x16 returns the pin levels as they stood two clock edges earlier. After a pin change, the first read still shows the old level and the second read shows the new one.
- R5: A write to 0x16 or to any unmapped address leaves both the latch and the direction register unchanged.
- R6: `rd_data` is 0x00 while `rd_en` is low, and also when the address is not one of 0x16, 0x17 or 0x18.
- R7: Bit n of `pad_oe` equals bit n of the direction register. It updates one cycle after the edge that wrote the register.
- R8: Bit n of `pad_out` equals bit n of the latch. It updates one cycle after the edge that wrote the latch.
- R9: Bit n of `pad_pu` is (NOT direction[n]) AND latch[n], with the same one-cycle lag. It is therefore never 1 on a pin whose output enable is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Bus address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, 0 when idle or unmapped |
| pin_in | input | 8 | External pin levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
A corrupted latch or direction bit reaches the ports through two paths. It shows on the matching read address in the very next cycle. It also shows on the pad controls one cycle later, where one bad bit can make a pin drive when it should float or switch its pull-up on or off. A synchronizer stage that is too short or too long moves the first read that returns the new pin level one cycle early or late. The bench reads the pin address on both sides of that boundary to catch this. A write that leaks through the pin address or an unmapped address becomes visible on the next readback of the latch or the direction register.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_PIN   = 2'd1,
    SEL_DIR   = 2'd2,
    SEL_LATCH = 2'd3
  } port_sel_e;
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 6'h18,
  parameter logic [ADDR_W-1:0] DIR_ADDR   = 6'h17,
  parameter logic [ADDR_W-1:0] PIN_ADDR   = 6'h16
) (
  input  logic [ADDR_W-1:0] addr,
  output port_sel_e         sel
);
  always_comb begin
    if (addr == LATCH_ADDR)    sel = SEL_LATCH;
    else if (addr == DIR_ADDR) sel = SEL_DIR;
    else if (addr == PIN_ADDR) sel = SEL_PIN;
    else                       sel = SEL_NONE;
  end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  port_sel_e    sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else if (wr_en) begin
      if (sel == SEL_LATCH) latch_q <= wr_data;
      if (sel == SEL_DIR)   dir_q   <= wr_data;
    end
  end

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == SEL_PIN || sel == SEL_NONE)) |=> ($stable(latch_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_sync
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= pin_in;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] dir_q,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pad_oe[b]  <= 1'b0;
        pad_out[b] <= 1'b0;
        pad_pu[b]  <= 1'b0;
      end else begin
        pad_oe[b]  <= dir_q[b];
        pad_out[b] <= latch_q[b];
        pad_pu[b]  <= ~dir_q[b] & latch_q[b];
      end
    end
  end

  // R9
  pu_drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 6'h18,
  parameter logic [ADDR_W-1:0] DIR_ADDR   = 6'h17,
  parameter logic [ADDR_W-1:0] PIN_ADDR   = 6'h16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_en,
  output logic [W-1:0]      rd_data,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_pu
);
  port_sel_e    sel;
  logic [W-1:0] latch_q, dir_q, pin_sync;

  gpio_bus_decode #(
    .ADDR_W(ADDR_W), .LATCH_ADDR(LATCH_ADDR), .DIR_ADDR(DIR_ADDR), .PIN_ADDR(PIN_ADDR)
  ) u_decode (
    .addr(addr), .sel(sel)
  );

  gpio_cfg_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wr_data(wr_data),
    .latch_q(latch_q), .dir_q(dir_q)
  );

  gpio_pin_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sync(pin_sync)
  );

  gpio_pad_ctrl #(.W(W)) u_pads (
    .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .dir_q(dir_q),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_LATCH: rd_data = latch_q;
        SEL_DIR:   rd_data = dir_q;
        SEL_PIN:   rd_data = pin_sync;
        default:   rd_data = '0;
      endcase
    end
  end

  // R8
  latch_to_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == LATCH_ADDR) |=> ##1 (pad_out == $past(wr_data, 2)));

  // R7
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == DIR_ADDR) |=> ##1 (pad_oe == $past(wr_data, 2)));
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] pin_in = 8'hC3;
  logic [7:0] pad_oe, pad_out, pad_pu;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pops expected reads and compares
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rd_en) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard: read with no expectation, actual %02h expected none", rd_data);
        end else begin
          check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
      end
    end
  end

  task automatic pads(string tag, logic [7:0] oe, logic [7:0] o, logic [7:0] pu);
    #1;
    check({tag, " pad_oe"}, pad_oe, oe);
    check({tag, " pad_out"}, pad_out, o);
    check({tag, " pad_pu"}, pad_pu, pu);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    pads("R1 reset", 8'h00, 8'h00, 8'h00);
    rst_n = 1'b1;
    rd(6'h18, 8'h00, "R1 latch after reset");
    rd(6'h17, 8'h00, "R1 dir after reset");
    @(negedge clk); pads("R1 idle", 8'h00, 8'h00, 8'h00);

    // R6 idle read data
    @(negedge clk); addr = 6'h16; #1; check("R6 rd_en low", rd_data, 8'h00);

    wr(6'h18, 8'hA5);
    pads("R8 lag before update", 8'h00, 8'h00, 8'h00);
    @(negedge clk); pads("R8 R9 input pull-ups", 8'h00, 8'hA5, 8'hA5);
    rd(6'h18, 8'hA5, "R2 latch readback ignores pins");
    wr(6'h17, 8'h0F);
    pads("R7 lag before update", 8'h00, 8'hA5, 8'hA5);
    @(negedge clk); pads("R7 R9 mixed", 8'h0F, 8'hA5, 8'hA0);
    rd(6'h17, 8'h0F, "R3 dir readback");

    // R4 two-edge lag
    @(negedge clk); pin_in = 8'h3C;
    rd(6'h16, 8'hC3, "R4 first read old level");
    rd(6'h16, 8'h3C, "R4 second read new level");

    // R5 writes to pin or unmapped address
    wr(6'h16, 8'h77);
    wr(6'h20, 8'h99);
    rd(6'h18, 8'hA5, "R5 latch unchanged");
    rd(6'h17, 8'h0F, "R5 dir unchanged");
    @(negedge clk); pads("R5 pads unchanged", 8'h0F, 8'hA5, 8'hA0);

    rd(6'h20, 8'h00, "R6 unmapped read");
    rd(6'h3F, 8'h00, "R6 unmapped read high");

    // all outputs
    wr(6'h17, 8'hFF);
    wr(6'h18, 8'h5A);
    @(negedge clk); pads("R7 R8 R9 all outputs", 8'hFF, 8'h5A, 8'h00);
    // all inputs with pull-ups
    wr(6'h17, 8'h00);
    wr(6'h18, 8'hFF);
    @(negedge clk); pads("R9 all pull-ups", 8'h00, 8'hFF, 8'hFF);
    pin_in = 8'h00;
    rd(6'h16, 8'h3C, "R4 lag again");
    rd(6'h16, 8'h00, "R4 pins low");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule